// File: doc/BRIEF.md
# Processor Sleep and Wake-up Controller

This block sequences the low-power state of a small microcontroller core. When the instruction decoder reports that a sleep instruction is executing, the controller decides whether the sleep really happens. If an interrupt whose enable bit is set is already pending, the sleep is turned into a no-operation. Otherwise the controller gates the core clock off, pulses a clear to the watchdog and its scalers, and records in two status bits that a sleep took place.

While asleep, the controller watches for a wake source. A wake source is any interrupt whose own enable is set, or a watchdog time-out when the watchdog is enabled. On a wake it either resumes at once (RC oscillator mode) or first holds the clock off for an oscillator start-up interval, which is modelled by a counter. It then issues a one-cycle resume command. The global interrupt enable never blocks the wake-up. It only selects the kind of resume:
- In-line resume: the prefetched instruction after the sleep is the next one executed.
- Vector branch: the prefetched instruction runs, then the core inserts a dummy slot and jumps to address 0x0004.

An external reset returns everything to the power-up condition.

The state machine has three states:
- `ST_RUN`: clock on.
- `ST_SLEEP`: clock off, waiting for a wake source.
- `ST_OST`: clock off, start-up counter running.

It has four transitions:
- accept (`ST_RUN`→`ST_SLEEP`): a sleep strobe with no enabled interrupt pending.
- wake-slow (`ST_SLEEP`→`ST_OST`): a wake source in crystal mode.
- wake-fast (`ST_SLEEP`→`ST_RUN`): a wake source in RC mode.
- ready (`ST_OST`→`ST_RUN`): the counter reaches terminal count.

An external reset forces `ST_RUN` from any state.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, `core_clk_en`=1, `pd_flag`=1, `to_flag`=1, and `wdt_clear` and `resume_valid` are both 0.
- R2: A `sleep_exec` strobe sampled with no enabled interrupt pending is accepted. From the next cycle, `core_clk_en`=0, `pd_flag`=0 and `to_flag`=1, and `wdt_clear` is high for exactly that one cycle.
- R3: A `sleep_exec` strobe sampled while some bit i has both `irq_flag[i]` and `irq_en[i]` set is a no-operation. The clock stays on, `wdt_clear` stays 0, and `pd_flag`/`to_flag` are unchanged.
- R4: An enabled interrupt that rises just after the accepting edge does not cancel the sleep. The accept effects of R2 occur, and the wake follows on the very next edge.
- R5: In sleep, only an interrupt with its enable bit set, or `wdt_timeout` while `wdt_enable`=1, wakes the controller. A flag with a clear enable, or a time-out with the watchdog disabled, leaves `core_clk_en` at 0.
- R6: A wake caused while `wdt_enable` and `wdt_timeout` are both 1 clears `to_flag`. A wake by interrupt alone leaves `to_flag` at 1.
- R7: With `osc_rc_mode`=0, `core_clk_en` stays 0 for exactly OST_CYCLES (default 1024) cycles after the wake edge. It rises together with `resume_valid`, and the counter restarts from zero on every wake.
- R8: With `osc_rc_mode`=1, `core_clk_en` and `resume_valid` are both 1 in the cycle right after the wake edge.
- R9: `resume_valid` is a one-cycle pulse. With it, `resume_branch` equals `gie` as sampled at the issuing edge. `resume_addr` is VECTOR_ADDR (0x0004) when branching and 0 otherwise.
- R10: `ext_rst`=1 at an edge forces `ST_RUN`, sets `pd_flag`=1 and `to_flag`=1, and cancels any resume, including one whose start-up interval was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (free-running oscillator domain) |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ext_rst | input | 1 | Synchronous external device reset, active high |
| sleep_exec | input | 1 | One-cycle strobe: sleep instruction executing |
| irq_flag | input | N_IRQ | Per-source interrupt flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_enable | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| osc_rc_mode | input | 1 | 1 = RC oscillator, no start-up wait |
| core_clk_en | output | 1 | Core clock gate enable |
| wdt_clear | output | 1 | Clear pulse for watchdog, prescaler and postscaler |
| pd_flag | output | 1 | Power-down status bit |
| to_flag | output | 1 | Time-out status bit |
| resume_valid | output | 1 | One-cycle resume command |
| resume_branch | output | 1 | 1 = branch to vector after the prefetched instruction |
| resume_addr | output | ADDR_W | Vector address on a branching resume, else 0 |

## Verification
The bench targets the race between a pending interrupt and the sleep strobe. A design that samples the pending state one cycle late would either sleep with an interrupt already waiting, or drop the watchdog clear for a sleep that should complete.

It measures the start-up hold to the exact cycle, and does so twice, to expose an off-by-one terminal count or a counter that keeps its old value between wakes. It also checks masked sources and a disabled watchdog. Either one waking the core would show up as an early clock enable.

Finally, it checks that an external reset in the middle of start-up suppresses the resume pulse. It also checks that the time-out bit distinguishes a watchdog wake from an interrupt wake.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OST   = 2'd2
    } swc_state_t;
endpackage

// File: rtl/swc_pending_detect.sv
module swc_pending_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_enable,
    input  logic             wdt_timeout,
    output logic             irq_pending,
    output logic             wdt_wake,
    output logic             wake_any
);
    logic [N_IRQ-1:0] armed;

    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_src
            assign armed[g] = irq_flag[g] & irq_en[g];
        end
    endgenerate

    always_comb begin
        irq_pending = |armed;
        wdt_wake    = wdt_enable & wdt_timeout;
        wake_any    = irq_pending | wdt_wake;
    end
endmodule

// File: rtl/swc_startup_timer.sv
module swc_startup_timer #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(OST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != TERM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == TERM);

    // R7
    ost_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == '0));
endmodule

// File: rtl/swc_status_regs.sv
module swc_status_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic force_init,
    input  logic sleep_done,
    input  logic wdt_wake_evt,
    output logic pd_flag,
    output logic to_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_flag <= 1'b1;
            to_flag <= 1'b1;
        end else if (force_init) begin
            pd_flag <= 1'b1;
            to_flag <= 1'b1;
        end else if (sleep_done) begin
            pd_flag <= 1'b0;
            to_flag <= 1'b1;
        end else if (wdt_wake_evt) begin
            to_flag <= 1'b0;
        end
    end

    // R10
    pd_set_only_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_flag) |-> $past(force_init));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int          N_IRQ       = 8,
    parameter int          OST_CYCLES  = 1024,
    parameter int          ADDR_W      = 13,
    parameter logic [12:0] VECTOR_ADDR = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst,
    input  logic              sleep_exec,
    input  logic [N_IRQ-1:0]  irq_flag,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              gie,
    input  logic              wdt_enable,
    input  logic              wdt_timeout,
    input  logic              osc_rc_mode,
    output logic              core_clk_en,
    output logic              wdt_clear,
    output logic              pd_flag,
    output logic              to_flag,
    output logic              resume_valid,
    output logic              resume_branch,
    output logic [ADDR_W-1:0] resume_addr
);
    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VECTOR_ADDR);

    swc_state_t state_q, state_d;
    logic irq_pending, wdt_wake, wake_any, ost_done;
    logic accept, wake_evt, resume_go;

    swc_pending_detect #(.N_IRQ(N_IRQ)) i_pend (
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .wdt_enable  (wdt_enable),
        .wdt_timeout (wdt_timeout),
        .irq_pending (irq_pending),
        .wdt_wake    (wdt_wake),
        .wake_any    (wake_any)
    );

    swc_startup_timer #(.OST_CYCLES(OST_CYCLES)) i_ost (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (wake_evt),
        .run    (state_q == ST_OST),
        .done   (ost_done)
    );

    swc_status_regs i_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_init   (ext_rst),
        .sleep_done   (accept),
        .wdt_wake_evt (wake_evt && wdt_wake),
        .pd_flag      (pd_flag),
        .to_flag      (to_flag)
    );

    // Transition decode
    always_comb begin
        accept    = !ext_rst && (state_q == ST_RUN) && sleep_exec && !irq_pending;
        wake_evt  = !ext_rst && (state_q == ST_SLEEP) && wake_any;
        resume_go = !ext_rst && ((wake_evt && osc_rc_mode) ||
                                 ((state_q == ST_OST) && ost_done));
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (accept) state_d = ST_SLEEP;
            ST_SLEEP: if (wake_evt) state_d = osc_rc_mode ? ST_RUN : ST_OST;
            ST_OST:   if (ost_done) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
        if (ext_rst) state_d = ST_RUN;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_clear     <= 1'b0;
            resume_valid  <= 1'b0;
            resume_branch <= 1'b0;
            resume_addr   <= '0;
        end else begin
            wdt_clear     <= accept;
            resume_valid  <= resume_go;
            resume_branch <= resume_go && gie;
            resume_addr   <= (resume_go && gie) ? VEC : '0;
        end
    end

    assign core_clk_en = (state_q == ST_RUN);

    // R2
    wdt_clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> !wdt_clear);
    // R2
    wdt_clear_sleeping_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |-> (!core_clk_en && !pd_flag));
    // R3
    nop_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && sleep_exec && irq_pending && !ext_rst) |=>
            (core_clk_en && !wdt_clear && $stable(pd_flag)));
    // R9
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> (core_clk_en && $rose(core_clk_en)));
    // R10
    ext_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (core_clk_en && pd_flag && to_flag && !resume_valid));
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
    localparam int N_IRQ = 8;
    localparam int OSTC  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst = 1'b0, sleep_exec = 1'b0, gie = 1'b0;
    logic wdt_enable = 1'b0, wdt_timeout = 1'b0, osc_rc_mode = 1'b0;
    logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
    logic core_clk_en, wdt_clear, pd_flag, to_flag, resume_valid, resume_branch;
    logic [12:0] resume_addr;

    int checks = 0;
    int fails = 0;

    always #2ns clk = ~clk;

    sleep_wake_ctrl i_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sleep_exec(sleep_exec),
        .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .wdt_enable(wdt_enable),
        .wdt_timeout(wdt_timeout), .osc_rc_mode(osc_rc_mode),
        .core_clk_en(core_clk_en), .wdt_clear(wdt_clear), .pd_flag(pd_flag),
        .to_flag(to_flag), .resume_valid(resume_valid),
        .resume_branch(resume_branch), .resume_addr(resume_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe sleep for one edge; returns at the negedge after it.
    task automatic pulse_sleep();
        @(negedge clk) sleep_exec = 1'b1;
        @(negedge clk) sleep_exec = 1'b0;
    endtask

    // Count negedges with clock gated off, starting with the current one.
    task automatic count_off(output int n);
        n = 0;
        while (core_clk_en == 1'b0 && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 pd", pd_flag, 1);
        chk("R1 to", to_flag, 1);
        chk("R1 wdt_clear", wdt_clear, 0);
        chk("R1 resume", resume_valid, 0);
    endtask

    task automatic t_nop();
        irq_flag = 8'h02; irq_en = 8'h02;
        pulse_sleep();
        chk("R3 clk_en", core_clk_en, 1);
        chk("R3 wdt_clear", wdt_clear, 0);
        chk("R3 pd", pd_flag, 1);
        chk("R3 to", to_flag, 1);
        irq_flag = '0; irq_en = '0;
    endtask

    task automatic t_masked_then_crystal();
        int n;
        irq_flag = 8'h04; irq_en = 8'h00; gie = 1'b1; osc_rc_mode = 1'b0;
        pulse_sleep();
        chk("R2 clk_en", core_clk_en, 0);
        chk("R2 wdt_clear", wdt_clear, 1);
        chk("R2 pd", pd_flag, 0);
        chk("R2 to", to_flag, 1);
        @(negedge clk);
        chk("R2 wdt_clear single", wdt_clear, 0);
        repeat (5) @(negedge clk);
        chk("R5 masked flag no wake", core_clk_en, 0);
        irq_en = 8'h04;
        @(negedge clk);
        count_off(n);
        chk("R7 hold cycles", n, OSTC);
        chk("R7 resume", resume_valid, 1);
        chk("R9 branch", resume_branch, 1);
        chk("R9 addr", resume_addr, 4);
        chk("R6 to after irq wake", to_flag, 1);
        @(negedge clk);
        chk("R9 single pulse", resume_valid, 0);
        irq_flag = '0; irq_en = '0;
    endtask

    task automatic t_wdt_rc();
        osc_rc_mode = 1'b1; gie = 1'b0; wdt_enable = 1'b0;
        pulse_sleep();
        wdt_timeout = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 disabled wdt no wake", core_clk_en, 0);
        wdt_enable = 1'b1;
        @(negedge clk);
        chk("R8 clk_en", core_clk_en, 1);
        chk("R8 resume", resume_valid, 1);
        chk("R9 inline branch", resume_branch, 0);
        chk("R9 inline addr", resume_addr, 0);
        chk("R6 to cleared", to_flag, 0);
        wdt_timeout = 1'b0; wdt_enable = 1'b0; osc_rc_mode = 1'b0;
    endtask

    task automatic t_late_irq();
        int n;
        @(negedge clk) sleep_exec = 1'b1;
        @(posedge clk) #1ns irq_flag = 8'h80; irq_en = 8'h80;
        @(negedge clk) sleep_exec = 1'b0;
        chk("R4 wdt_clear", wdt_clear, 1);
        chk("R4 pd", pd_flag, 0);
        chk("R4 to", to_flag, 1);
        count_off(n);
        chk("R4 R7 sleep+hold", n, OSTC + 1);
        chk("R4 resume", resume_valid, 1);
        irq_flag = '0; irq_en = '0;
    endtask

    task automatic t_ext_rst();
        int seen;
        pulse_sleep();
        irq_flag = 8'h01; irq_en = 8'h01;
        repeat (100) @(negedge clk);
        irq_flag = '0; irq_en = '0;
        ext_rst = 1'b1;
        @(negedge clk) ext_rst = 1'b0;
        chk("R10 clk_en", core_clk_en, 1);
        chk("R10 pd", pd_flag, 1);
        chk("R10 to", to_flag, 1);
        seen = 0;
        for (int i = 0; i < OSTC + 50; i++) begin
            if (resume_valid) seen++;
            @(negedge clk);
        end
        chk("R10 resume cancelled", seen, 0);
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nop();
        t_masked_then_crystal();
        t_wdt_rc();
        t_late_irq();
        t_ext_rst();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule